// File: doc/BRIEF.md
# ADPCM Playback Address Sequencer

This block paces the playback of 4-bit ADPCM codes and hands them, one per clock, to a separate decoder. A fractional phase accumulator adds a programmable rate step on every output tick. The whole-number overflow of that sum is the number of codes the decoder must take for that tick, so a high rate can consume several codes per tick. The remaining fraction is brought out for the decoder's interpolator.

Codes come from one of two sources. The first is an external byte memory, walked through a nibble-granular address: each byte holds two codes, high nibble first. The walk has an optional wrap point and a programmable end, where playback either loops back to the start address or finishes. The second source is a host that writes bytes one at a time. A ready flag asks the host for the next byte.

The decoder arithmetic and the memory are outside the block. Memory reads are combinational: the block drives `mem_addr` with `mem_rd`, and it uses `mem_rdata` in the same cycle.

Top module: `adpcm_playback_seq`

## Requirements
- R1: After reset `busy`=0, `eos`=0, `brdy`=1, and no code or decoder-reset strobe is produced. The wrap address resets to all ones, so with the default wrap address a play starting at byte 0xFFFFFF wraps at once to byte 0.
- R2: A control write with bit 7 set and bit 0 clear is a start. A start sets `busy`, clears `eos`, zeroes the phase and any pending count, and pulses `dec_reset` one cycle later. The mode is control bits [7:5]: 3'b101 plays from memory, beginning at the start byte's high nibble. 3'b100 plays from the host.
- R3: On each tick during play, the phase gains `rate_step`, whose low FRAC_W bits are the fraction. The overflow sets how many codes follow, one per cycle. `phase_frac` keeps only the fractional part.
- R4: In memory mode an even nibble address reads byte address>>1 and emits its high nibble. An odd nibble address emits the low nibble of the byte held from that read, with no new memory read.
- R5: In memory mode, before each code, a nibble address equal to (wrap byte<<1) is replaced by 0. The address registers are written through `addr_sel`: 0 is start, 1 is end, 2 is wrap.
- R6: In memory mode, a code step that finds the address at (end byte<<1) without repeat (control bit 4) does the following: it sets `eos`, clears `busy`, pulses `dec_reset`, emits no code and stops.
- R7: The same step with repeat set reloads the address from the start byte and pulses `dec_reset`. Playback continues from the start byte's high nibble on the next pending step.
- R8: The nibble address is ADDR_W+1 bits and wraps modulo that width, so byte 0xFFFFFF is followed by byte 0.
- R9: In host mode the held byte starts at zero. An even address emits its high nibble. An odd address emits its low nibble, then loads the pending host byte and sets `brdy`. A host write during host-mode play clears `brdy`.
- R10: In host mode, if no new host byte has been written, the previous host byte is loaded again and played again, with no error indication.
- R11: A control write with bit 0 set stops playback and clears `busy`, and `brdy` reads 1 in the next cycle. Later ticks produce no codes.
- R12: A start whose mode is not a play mode (e.g. 3'b110) sets `busy` and strobes `dec_reset`, but ticks then produce no codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_data | input | 8 | Control byte: [7] start, [6] record, [5] memory source, [4] repeat, [0] stop |
| addr_wr | input | 1 | Address register write strobe |
| addr_sel | input | 2 | 0 start, 1 end, 2 wrap |
| addr_wdata | input | ADDR_W | Byte address written |
| rate_step | input | STEP_W | Phase increment per tick, FRAC_W fraction bits |
| tick | input | 1 | Output-sample tick |
| host_wr | input | 1 | Host data byte write strobe |
| host_data | input | 8 | Host data byte |
| mem_rd | output | 1 | Memory byte read this cycle |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 8 | Memory read data, same cycle |
| nib_valid | output | 1 | A code is presented to the decoder |
| nib_data | output | 4 | ADPCM code |
| dec_reset | output | 1 | Decoder state reset strobe |
| phase_frac | output | FRAC_W | Fractional phase for interpolation |
| busy | output | 1 | Playback active |
| eos | output | 1 | End of sample reached |
| brdy | output | 1 | Host byte buffer ready for a new byte |

## Verification
The bound checker tests, on every cycle, the temporal links between flags and strobes. `busy` may fall only after a stop event, a rising `eos` comes with a decoder reset, and a start or repeat strobes the decoder. Memory reads happen only at even nibble addresses, `brdy` falls only after a host write, and a stop write leaves the block idle and ready. Only the bench's scenarios can show that the code stream is correct. These scenarios cover the nibble order, the number of codes per tick and the phase fraction, wrap and end handling, modulo address wrap, and host byte reuse. For these, the scoreboard compares every code and decoder reset against a sequence built from the requirements.

// File: rtl/adpcm_seq_pkg.sv
package adpcm_seq_pkg;

  localparam logic [2:0] MODE_PLAY_HOST = 3'b100;
  localparam logic [2:0] MODE_PLAY_MEM  = 3'b101;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_END   = 2'd1;
  localparam logic [1:0] SEL_WRAP  = 2'd2;

  function automatic logic is_play_mode(input logic [2:0] mode);
    return (mode == MODE_PLAY_HOST) || (mode == MODE_PLAY_MEM);
  endfunction

  // high nibble first: odd address selects the low half
  function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic odd);
    return odd ? b[3:0] : b[7:4];
  endfunction

endpackage

// File: rtl/adpcm_rate_accum.sv
module adpcm_rate_accum #(
  parameter int STEP_W = 18,
  parameter int FRAC_W = 16,
  parameter int CNT_W  = STEP_W - FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick_en,
  input  logic              consume,
  input  logic [STEP_W-1:0] step,
  output logic [FRAC_W-1:0] frac,
  output logic              pend_nz
);
  localparam int SUM_W   = STEP_W + 1;
  localparam int CARRY_W = SUM_W - FRAC_W;

  logic [FRAC_W-1:0]  frac_q;
  logic [CNT_W-1:0]   pend_q;
  logic [SUM_W-1:0]   sum;
  logic [CARRY_W-1:0] carry;

  always_comb begin
    sum   = {1'b0, step} + SUM_W'(frac_q);
    carry = tick_en ? sum[SUM_W-1:FRAC_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      pend_q <= '0;
    end else if (clear) begin
      frac_q <= '0;
      pend_q <= '0;
    end else begin
      if (tick_en) frac_q <= sum[FRAC_W-1:0];
      pend_q <= pend_q + CNT_W'(carry) - CNT_W'(consume);
    end
  end

  assign frac    = frac_q;
  assign pend_nz = (pend_q != '0);
endmodule

// File: rtl/adpcm_addr_step.sv
module adpcm_addr_step #(
  parameter int NA_W = 25
) (
  input  logic [NA_W-1:0] cur,
  input  logic            use_bounds,
  input  logic [NA_W-1:0] wrap_na,
  input  logic [NA_W-1:0] end_na,
  output logic [NA_W-1:0] eff,
  output logic            at_end,
  output logic [NA_W-1:0] nxt
);
  always_comb begin
    eff    = (use_bounds && (cur == wrap_na)) ? '0 : cur;
    at_end = use_bounds && (eff == end_na);
    nxt    = eff + NA_W'(1);
  end
endmodule

// File: rtl/adpcm_host_buf.sv
module adpcm_host_buf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       taken,
  input  logic       force_rdy,
  output logic [7:0] byte_q,
  output logic       rdy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      rdy    <= 1'b1;
    end else begin
      if (wr_en) byte_q <= wr_data;
      if (force_rdy)  rdy <= 1'b1;
      else if (wr_en) rdy <= 1'b0;
      else if (taken) rdy <= 1'b1;
    end
  end
endmodule

// File: rtl/adpcm_playback_seq.sv
module adpcm_playback_seq
  import adpcm_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int STEP_W = 18,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_data,
  input  logic              addr_wr,
  input  logic [1:0]        addr_sel,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic [STEP_W-1:0] rate_step,
  input  logic              tick,
  input  logic              host_wr,
  input  logic [7:0]        host_data,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              nib_valid,
  output logic [3:0]        nib_data,
  output logic              dec_reset,
  output logic [FRAC_W-1:0] phase_frac,
  output logic              busy,
  output logic              eos,
  output logic              brdy
);
  localparam int NA_W  = ADDR_W + 1;
  localparam int CNT_W = STEP_W - FRAC_W + 2;

  logic [ADDR_W-1:0] start_q, end_q, wrap_q;
  logic [2:0]        mode_q;
  logic              rpt_q, play_q, busy_q, eos_q;
  logic [NA_W-1:0]   addr_q;
  logic [7:0]        held_q;
  logic              nib_v_q, dres_q;
  logic [3:0]        nib_q;

  // named events, also observed by the checker
  logic ev_ctrl_rst, ev_start, ev_step, ev_end, ev_rpt, ev_stop_end, ev_nib, ev_stop;
  logic ev_host_take, ev_host_wr, ev_eff_odd, src_mem, pend_nz;
  logic [NA_W-1:0] a_eff, a_next;
  logic at_end;
  logic [3:0] cur_nib;
  logic [7:0] host_byte;

  assign src_mem     = mode_q[0];
  assign ev_ctrl_rst = ctrl_wr && ctrl_data[0];
  assign ev_start    = ctrl_wr && !ctrl_data[0] && ctrl_data[7];
  assign ev_step     = play_q && pend_nz && !ctrl_wr;
  assign ev_end      = ev_step && at_end;
  assign ev_rpt      = ev_end && rpt_q;
  assign ev_stop_end = ev_end && !rpt_q;
  assign ev_nib      = ev_step && !at_end;
  assign ev_stop     = ev_stop_end || ev_ctrl_rst;
  assign ev_eff_odd  = a_eff[0];
  assign ev_host_take = ev_nib && !src_mem && a_eff[0];
  assign ev_host_wr  = host_wr && play_q && !src_mem;

  adpcm_rate_accum #(.STEP_W(STEP_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n),
    .clear(ev_start || ev_stop),
    .tick_en(tick && play_q && !ctrl_wr),
    .consume(ev_nib),
    .step(rate_step),
    .frac(phase_frac),
    .pend_nz(pend_nz)
  );

  adpcm_addr_step #(.NA_W(NA_W)) u_addr (
    .cur(addr_q), .use_bounds(src_mem),
    .wrap_na({wrap_q, 1'b0}), .end_na({end_q, 1'b0}),
    .eff(a_eff), .at_end(at_end), .nxt(a_next)
  );

  adpcm_host_buf u_host (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ev_host_wr), .wr_data(host_data),
    .taken(ev_host_take), .force_rdy(ev_ctrl_rst),
    .byte_q(host_byte), .rdy(brdy)
  );

  always_comb begin
    if (src_mem && !a_eff[0]) cur_nib = pick_nibble(mem_rdata, 1'b0);
    else                      cur_nib = pick_nibble(held_q, a_eff[0]);
  end

  assign mem_rd   = ev_nib && src_mem && !a_eff[0];
  assign mem_addr = a_eff[NA_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      wrap_q  <= '1;
    end else if (addr_wr) begin
      case (addr_sel)
        SEL_START: start_q <= addr_wdata;
        SEL_END:   end_q   <= addr_wdata;
        SEL_WRAP:  wrap_q  <= addr_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      rpt_q   <= 1'b0;
      play_q  <= 1'b0;
      busy_q  <= 1'b0;
      eos_q   <= 1'b0;
      addr_q  <= '0;
      held_q  <= '0;
      nib_v_q <= 1'b0;
      nib_q   <= '0;
      dres_q  <= 1'b0;
    end else begin
      nib_v_q <= ev_nib;
      dres_q  <= ev_start || ev_rpt || ev_stop_end;
      if (ev_nib) nib_q <= cur_nib;
      if (ctrl_wr) begin
        mode_q <= ctrl_data[0] ? 3'b000 : ctrl_data[7:5];
        rpt_q  <= ctrl_data[4] && !ctrl_data[0];
      end
      if (ev_ctrl_rst) begin
        play_q <= 1'b0;
        busy_q <= 1'b0;
      end else if (ev_start) begin
        play_q <= is_play_mode(ctrl_data[7:5]);
        busy_q <= 1'b1;
        eos_q  <= 1'b0;
        held_q <= '0;
        addr_q <= ctrl_data[5] ? {start_q, 1'b0} : '0;
      end else if (ctrl_wr) begin
        play_q <= 1'b0;
      end else begin
        if (ev_stop_end) begin
          play_q <= 1'b0;
          busy_q <= 1'b0;
          eos_q  <= 1'b1;
        end
        if (ev_rpt) addr_q <= {start_q, 1'b0};
        if (ev_nib) begin
          addr_q <= a_next;
          if (src_mem && !a_eff[0]) held_q <= mem_rdata;
          if (ev_host_take)         held_q <= host_byte;
        end
      end
    end
  end

  assign nib_valid = nib_v_q;
  assign nib_data  = nib_q;
  assign dec_reset = dres_q;
  assign busy      = busy_q;
  assign eos       = eos_q;
endmodule

// File: rtl/adpcm_seq_chk.sv
module adpcm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       eos,
  input logic       brdy,
  input logic       dec_reset,
  input logic       nib_valid,
  input logic       host_wr,
  input logic       mem_rd,
  input logic       ev_eff_odd,
  input logic       ev_stop,
  input logic       ev_rpt,
  input logic       ev_ctrl_rst
);
  assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ev_stop));

  assert_eos_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos) |-> (!busy && dec_reset));

  assert_start_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dec_reset);

  assert_even_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !ev_eff_odd);

  assert_brdy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brdy) |-> $past(host_wr));

  assert_ctrl_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl_rst |=> (!busy && brdy));

  assert_repeat_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rpt |=> (dec_reset && busy));

  assert_code_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid |-> busy);
endmodule

bind adpcm_playback_seq adpcm_seq_chk u_seq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .eos(eos), .brdy(brdy),
  .dec_reset(dec_reset), .nib_valid(nib_valid), .host_wr(host_wr),
  .mem_rd(mem_rd), .ev_eff_odd(ev_eff_odd), .ev_stop(ev_stop),
  .ev_rpt(ev_rpt), .ev_ctrl_rst(ev_ctrl_rst)
);

// File: tb/adpcm_playback_seq_bench.sv
`timescale 1ns/1ps
module adpcm_playback_seq_bench;
  localparam int ADDR_W = 24;
  localparam int STEP_W = 18;
  localparam int FRAC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 1'b0;
  logic [7:0] ctrl_data = '0;
  logic addr_wr = 1'b0;
  logic [1:0] addr_sel = '0;
  logic [ADDR_W-1:0] addr_wdata = '0;
  logic [STEP_W-1:0] rate_step = '0;
  logic tick = 1'b0;
  logic host_wr = 1'b0;
  logic [7:0] host_data = '0;
  logic mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_rdata;
  logic nib_valid, dec_reset, busy, eos, brdy;
  logic [3:0] nib_data;
  logic [FRAC_W-1:0] phase_frac;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";
  logic [4:0] exp_q[$];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  adpcm_playback_seq #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .FRAC_W(FRAC_W)) u_adpcm_playback_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .addr_wr(addr_wr), .addr_sel(addr_sel), .addr_wdata(addr_wdata),
    .rate_step(rate_step), .tick(tick), .host_wr(host_wr), .host_data(host_data),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .nib_valid(nib_valid), .nib_data(nib_data), .dec_reset(dec_reset),
    .phase_frac(phase_frac), .busy(busy), .eos(eos), .brdy(brdy)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: codes and decoder resets in order
  always @(negedge clk) begin
    if (rst_n) begin
      if (dec_reset) begin
        if (exp_q.size() == 0) check(1'b0, cur_req, "unexpected decoder reset", 5'h10, 0);
        else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          check(e == 5'h10, cur_req, "stream item (reset)", 5'h10, int'(e));
        end
      end
      if (nib_valid) begin
        if (exp_q.size() == 0) check(1'b0, cur_req, "unexpected code", int'(nib_data), 0);
        else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          check(e == {1'b0, nib_data}, cur_req, "stream item (code)", int'({1'b0, nib_data}), int'(e));
        end
      end
    end
  end

  task automatic push_rst();
    exp_q.push_back(5'h10);
  endtask
  task automatic push_nib(input logic [3:0] n);
    exp_q.push_back({1'b0, n});
  endtask
  task automatic push_byte(input logic [ADDR_W-1:0] a);
    logic [7:0] b;
    b = mem_byte(a);
    push_nib(b[7:4]);
    push_nib(b[3:0]);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_data = v;
    @(negedge clk); ctrl_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask
  task automatic wr_addr(input logic [1:0] sel, input logic [ADDR_W-1:0] v);
    @(negedge clk); addr_wr = 1'b1; addr_sel = sel; addr_wdata = v;
    @(negedge clk); addr_wr = 1'b0;
  endtask
  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (7) @(negedge clk);
    end
  endtask
  task automatic host_write(input logic [7:0] v);
    @(negedge clk); host_wr = 1'b1; host_data = v;
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk);
  endtask
  task automatic drained(input string req);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, "expected items left", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(eos == 1'b0, "R1", "eos", eos, 0);
    check(brdy == 1'b1, "R1", "brdy", brdy, 1);
    check(nib_valid == 1'b0 && dec_reset == 1'b0, "R1", "strobes", nib_valid, 0);

    // R1 default wrap address all ones: 0xFFFFFF -> byte 0 at once
    rate_step = 18'h10000;
    wr_addr(2'd0, 24'hFFFFFF);
    wr_addr(2'd1, 24'h000001);
    push_rst(); push_byte(24'h0); push_rst();
    wr_ctrl(8'hA0);
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    do_ticks(3);
    drained("R1");

    // R4/R6 memory play to end, one code per tick
    cur_req = "R4";
    wr_addr(2'd0, 24'h000010);
    wr_addr(2'd1, 24'h000012);
    push_rst(); push_byte(24'h10); push_byte(24'h11); push_rst();
    wr_ctrl(8'hA0);
    check(eos == 1'b0, "R2", "eos cleared by start", eos, 0);
    do_ticks(5);
    check(eos == 1'b1, "R6", "eos at end", eos, 1);
    check(busy == 1'b0, "R6", "busy at end", busy, 0);
    do_ticks(2);
    drained("R6");

    // R3 three codes per tick
    cur_req = "R3";
    rate_step = 18'h30000;
    wr_addr(2'd0, 24'h000040);
    wr_addr(2'd1, 24'h000043);
    push_rst(); push_byte(24'h40); push_byte(24'h41); push_byte(24'h42); push_rst();
    wr_ctrl(8'hA0);
    do_ticks(3);
    check(eos == 1'b1, "R3", "eos after 3 ticks", eos, 1);
    drained("R3");

    // R3 fractional phase 1.5 per tick
    rate_step = 18'h18000;
    wr_addr(2'd0, 24'h000050);
    wr_addr(2'd1, 24'h000060);
    push_rst(); push_byte(24'h50); exp_q.push_back({1'b0, mem_byte(24'h51) >> 4});
    wr_ctrl(8'hA0);
    check(phase_frac == 16'h0000, "R2", "phase zero after start", phase_frac, 0);
    do_ticks(1);
    check(phase_frac == 16'h8000, "R3", "phase after tick 1", phase_frac, 16'h8000);
    do_ticks(1);
    check(phase_frac == 16'h0000, "R3", "phase after tick 2", phase_frac, 0);
    wr_ctrl(8'h01);
    drained("R3");

    // R7 repeat
    cur_req = "R7";
    rate_step = 18'h10000;
    wr_addr(2'd0, 24'h000020);
    wr_addr(2'd1, 24'h000021);
    push_rst(); push_byte(24'h20); push_rst(); push_byte(24'h20);
    wr_ctrl(8'hB0);
    do_ticks(4);
    check(busy == 1'b1 && eos == 1'b0, "R7", "still playing with repeat", busy, 1);
    wr_ctrl(8'h01);
    drained("R7");

    // R5 wrap address
    cur_req = "R5";
    wr_addr(2'd2, 24'h000031);
    wr_addr(2'd0, 24'h000030);
    wr_addr(2'd1, 24'h000001);
    push_rst(); push_byte(24'h30); push_byte(24'h0); push_rst();
    wr_ctrl(8'hA0);
    do_ticks(5);
    check(eos == 1'b1, "R5", "eos after wrap", eos, 1);
    drained("R5");

    // R8 modulo wrap of the nibble address
    cur_req = "R8";
    wr_addr(2'd2, 24'h000123);
    wr_addr(2'd0, 24'hFFFFFF);
    wr_addr(2'd1, 24'h000001);
    push_rst(); push_byte(24'hFFFFFF); push_byte(24'h0); push_rst();
    wr_ctrl(8'hA0);
    do_ticks(5);
    check(eos == 1'b1 && busy == 1'b0, "R8", "eos after modulo wrap", eos, 1);
    drained("R8");

    // R9/R10 host-fed play
    cur_req = "R9";
    push_rst(); push_nib(4'h0); push_nib(4'h0);
    push_nib(4'hA); push_nib(4'hB); push_nib(4'hA); push_nib(4'hB);
    wr_ctrl(8'h80);
    host_write(8'hAB);
    check(brdy == 1'b0, "R9", "brdy after host write", brdy, 0);
    do_ticks(1);
    check(brdy == 1'b0, "R9", "brdy after even code", brdy, 0);
    do_ticks(1);
    check(brdy == 1'b1, "R9", "brdy after odd code", brdy, 1);
    cur_req = "R10";
    do_ticks(4);
    check(brdy == 1'b1, "R10", "brdy on reuse", brdy, 1);
    drained("R10");

    // R11 control stop
    cur_req = "R11";
    host_write(8'h5E);
    check(brdy == 1'b0, "R9", "brdy cleared again", brdy, 0);
    wr_ctrl(8'h01);
    check(busy == 1'b0, "R11", "busy after stop", busy, 0);
    check(brdy == 1'b1, "R11", "brdy after stop", brdy, 1);
    do_ticks(3);
    drained("R11");

    // R12 record mode start: busy, no codes
    cur_req = "R12";
    push_rst();
    wr_ctrl(8'hC0);
    do_ticks(3);
    check(busy == 1'b1, "R12", "busy in record mode", busy, 1);
    wr_ctrl(8'h01);
    drained("R12");

    finish_run();
  end
endmodule